// File: doc/BRIEF.md
# Scaled ALU and Accumulator Datapath

This block is the arithmetic core of a fixed-point signal processing pipeline. It keeps a 32-bit twos-complement accumulator. A 16-bit operand is sign-extended and moved left by a programmable count before it meets the accumulator in a load, add or subtract. Bitwise AND, OR and XOR act on the accumulator's low word and leave its high word alone. Add and subtract wrap modulo 2^32. A sticky flag records any signed overflow, and a zero indication follows the accumulator's value.

The store path scales the accumulator as a whole and offers three left shifts: none, one place and four places. It returns the upper 16 bits of the shifted value, which suits rescaling a fractional result on its way back to memory. A fourth selection returns the low word unshifted. The caller decodes instructions and owns the memory. It supplies an opcode, the operand, a shift count and a store selection each cycle, with an enable that qualifies the update.

Top module: `acc_datapath`

## Requirements
- R1: While rst_ni is low, the accumulator and the overflow flag are zero and zero_o is high.
- R2: Opcode 0 (load) writes the 16-bit operand, sign-extended to 32 bits and shifted left by shamt_i places with zeros entering at the bottom. A count above 16 acts as 16.
- R3: Opcode 1 (add) adds the shifted operand from R2 to the accumulator, modulo 2^32.
- R4: Opcode 2 (subtract) subtracts the shifted operand from R2 from the accumulator, modulo 2^32.
- R5: Opcodes 3, 4 and 5 (AND, OR, XOR) combine the zero-extended, unshifted operand with accumulator bits 15..0. Bits 31..16 keep their value.
- R6: When en_i is low, the accumulator and the overflow flag keep their values whatever the opcode is.
- R7: ovf_o goes high after an add or subtract whose true signed result lies outside the 32-bit range. It then stays high until a load or a reset clears it.
- R8: zero_o is high exactly when the accumulator equals zero.
- R9: st_data_o depends on st_sel_i. Values 0, 1 and 2 return bits 31..16 of the accumulator shifted left by 0, 1 and 4 places respectively. Value 3 returns accumulator bits 15..0.
- R10: Opcodes 6 and 7 leave both the accumulator and the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Update enable for the accumulator and flag |
| op_i | input | 3 | Operation code |
| opnd_i | input | 16 | Operand from memory or an immediate field |
| shamt_i | input | 5 | Input shift count, 0..16 (larger values clamp) |
| st_sel_i | input | 2 | Store word and scaling select |
| st_data_o | output | 16 | Word to be stored |
| acc_o | output | 32 | Accumulator value |
| zero_o | output | 1 | Accumulator is zero |
| ovf_o | output | 1 | Sticky signed overflow flag |

## Verification
The assertions assume that en_i, op_i and opnd_i are known, two-valued signals at each rising edge while reset is released. They also assume that no input changes near that edge. The bench drives every input on the falling edge and drops en_i shortly after each active edge, so every enabled operation takes effect exactly once. It sweeps all 32 shift counts against every opcode and against operands at the sign and magnitude extremes. This covers the clamped counts as well as the legal ones, so the sign-preservation assertion in the input shifter is reached on every path.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_HI_SH0 = 2'd0,
    ST_HI_SH1 = 2'd1,
    ST_HI_SH4 = 2'd2,
    ST_LO     = 2'd3
  } st_sel_e;

  function automatic logic is_bool(op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/in_shifter.sv
module in_shifter #(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SHW = 5
) (
  input  logic [DW-1:0]  opnd_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [AW-1:0]  shifted_o
);
  localparam int MAX_SH = AW - DW;

  logic [SHW-1:0] sh_c;
  logic [AW-1:0]  stg [SHW+1];

  // counts past the word boundary clamp to the maximum
  assign sh_c   = (32'(shamt_i) > MAX_SH) ? SHW'(MAX_SH) : shamt_i;
  assign stg[0] = {{(AW-DW){opnd_i[DW-1]}}, opnd_i};

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stg[s+1] = sh_c[s] ? (stg[s] << (1 << s)) : stg[s];
  end

  assign shifted_o = stg[SHW];

  always_comb begin
    if (!$isunknown({opnd_i, shamt_i}))
      AST_SIGN_KEEP: assert (shifted_o[AW-1] == opnd_i[DW-1]); // R2
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  op_e            op_i,
  input  logic [AW-1:0]  acc_i,
  input  logic [AW-1:0]  shifted_i,
  input  logic [DW-1:0]  opnd_i,
  output logic [AW-1:0]  acc_nxt_o,
  output logic           ovf_set_o,
  output logic           ovf_clr_o
);
  logic [AW-1:0] sum, diff;
  logic [DW-1:0] lo;

  assign sum  = acc_i + shifted_i;
  assign diff = acc_i - shifted_i;

  always_comb begin
    lo        = acc_i[DW-1:0];
    acc_nxt_o = acc_i;
    ovf_set_o = 1'b0;
    ovf_clr_o = 1'b0;
    unique case (op_i)
      OP_LOAD: begin
        acc_nxt_o = shifted_i;
        ovf_clr_o = 1'b1;
      end
      OP_ADD: begin
        acc_nxt_o = sum;
        ovf_set_o = (acc_i[AW-1] == shifted_i[AW-1]) && (sum[AW-1] != acc_i[AW-1]);
      end
      OP_SUB: begin
        acc_nxt_o = diff;
        ovf_set_o = (acc_i[AW-1] != shifted_i[AW-1]) && (diff[AW-1] != acc_i[AW-1]);
      end
      OP_AND:  acc_nxt_o = {acc_i[AW-1:DW], lo & opnd_i};
      OP_OR:   acc_nxt_o = {acc_i[AW-1:DW], lo | opnd_i};
      OP_XOR:  acc_nxt_o = {acc_i[AW-1:DW], lo ^ opnd_i};
      default: acc_nxt_o = acc_i;
    endcase
  end
endmodule

// File: rtl/out_shifter.sv
module out_shifter
  import acc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SHA = 1,
  parameter int SHB = 4
) (
  input  logic [AW-1:0] acc_i,
  input  st_sel_e       sel_i,
  output logic [DW-1:0] data_o
);
  localparam int NSH = 3;

  function automatic int shv(int g);
    return (g == 0) ? 0 : (g == 1) ? SHA : SHB;
  endfunction

  logic [DW-1:0] hi_w [NSH];

  for (genvar g = 0; g < NSH; g++) begin : g_scale
    logic [AW-1:0] sc;
    assign sc      = acc_i << shv(g);
    assign hi_w[g] = sc[AW-1:AW-DW];
  end

  always_comb begin
    unique case (sel_i)
      ST_HI_SH0: data_o = hi_w[0];
      ST_HI_SH1: data_o = hi_w[1];
      ST_HI_SH4: data_o = hi_w[2];
      default:   data_o = acc_i[DW-1:0];
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW  = 2 * DW,
  localparam int SHW = $clog2(AW - DW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [2:0]     op_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [1:0]     st_sel_i,
  output logic [DW-1:0]  st_data_o,
  output logic [AW-1:0]  acc_o,
  output logic           zero_o,
  output logic           ovf_o
);
  op_e           op;
  logic [AW-1:0] acc_q, acc_nxt, shifted;
  logic          ovf_q, ovf_set, ovf_clr;

  assign op = op_e'(op_i);

  in_shifter #(.DW(DW), .AW(AW), .SHW(SHW)) u_in_sh (
    .opnd_i   (opnd_i),
    .shamt_i  (shamt_i),
    .shifted_o(shifted)
  );

  acc_alu #(.DW(DW), .AW(AW)) u_alu (
    .op_i     (op),
    .acc_i    (acc_q),
    .shifted_i(shifted),
    .opnd_i   (opnd_i),
    .acc_nxt_o(acc_nxt),
    .ovf_set_o(ovf_set),
    .ovf_clr_o(ovf_clr)
  );

  out_shifter #(.DW(DW), .AW(AW), .SHA(1), .SHB(4)) u_out_sh (
    .acc_i (acc_q),
    .sel_i (st_sel_e'(st_sel_i)),
    .data_o(st_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (en_i) begin
      acc_q <= acc_nxt;
      if (ovf_clr)      ovf_q <= 1'b0;
      else if (ovf_set) ovf_q <= 1'b1;
    end
  end

  assign acc_o  = acc_q;
  assign ovf_o  = ovf_q;
  assign zero_o = ~|acc_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q) && $stable(ovf_q)); // R6
  AST_BOOL_HIGH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && is_bool(op) |=> acc_q[AW-1:DW] == $past(acc_q[AW-1:DW])); // R5
  AST_LOAD_CLEARS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op == OP_LOAD |=> !ovf_q); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !(en_i && op == OP_LOAD) |=> ovf_q); // R7
  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op == OP_RSV6 || op == OP_RSV7) |=> $stable(acc_q) && $stable(ovf_q)); // R10
endmodule

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] opnd = '0;
  logic [4:0]  sh = '0;
  logic [1:0]  sel = '0;
  logic [15:0] st_data;
  logic [31:0] acc;
  logic        zero, ovf;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_acc = '0;
  bit          m_ovf = 1'b0;

  always #2.5 clk = ~clk;

  acc_datapath u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .opnd_i(opnd),
    .shamt_i(sh), .st_sel_i(sel), .st_data_o(st_data), .acc_o(acc),
    .zero_o(zero), .ovf_o(ovf)
  );

  function automatic logic [31:0] scaled(logic [15:0] v, int s);
    longint x = longint'($signed(v));
    int c = (s > 16) ? 16 : s;
    x = x * (longint'(1) << c);
    return x[31:0];
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    longint a;
    chk(req, acc, m_acc);
    chk("R7", ovf, m_ovf);
    chk("R8", zero, m_acc == 0);
    for (int k = 0; k < 4; k++) begin
      sel = k[1:0];
      #0.1;
      a = longint'(m_acc);
      if (k == 3) chk("R9", st_data, m_acc[15:0]);
      else begin
        a = a << ((k == 0) ? 0 : (k == 1) ? 1 : 4);
        chk("R9", st_data, a[31:16]);
      end
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic e, logic [2:0] o, logic [15:0] v, int s, string req);
    longint r;
    logic [31:0] b;
    en = e; op = o; opnd = v; sh = s[4:0];
    @(posedge clk);
    #1 en = 1'b0;
    b = scaled(v, s);
    if (e) begin
      case (o)
        3'd0: begin m_acc = b; m_ovf = 1'b0; end
        3'd1: begin
          r = longint'($signed(m_acc)) + longint'($signed(b));
          if (r > 64'sd2147483647 || r < -64'sd2147483648) m_ovf = 1'b1;
          m_acc = r[31:0];
        end
        3'd2: begin
          r = longint'($signed(m_acc)) - longint'($signed(b));
          if (r > 64'sd2147483647 || r < -64'sd2147483648) m_ovf = 1'b1;
          m_acc = r[31:0];
        end
        3'd3: m_acc[15:0] = m_acc[15:0] & v;
        3'd4: m_acc[15:0] = m_acc[15:0] | v;
        3'd5: m_acc[15:0] = m_acc[15:0] ^ v;
        default: ;
      endcase
    end
    @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] vals [7];
    string tags [8];
    vals = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234, 16'ha5c3};
    tags = '{"R2", "R3", "R4", "R5", "R5", "R5", "R10", "R10"};
    repeat (3) @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 7; i++)
        for (int s = 0; s < 32; s++) begin
          step(1'b1, 3'd0, vals[(i + s) % 7], (s * 7) % 17, "R2");
          step(1'b1, o[2:0], vals[i], s, tags[o]);
          step(1'b0, o[2:0], vals[(i + 3) % 7], s, "R6");
        end

    // sticky overflow sequence, R7
    step(1'b1, 3'd0, 16'h7fff, 16, "R2");
    step(1'b1, 3'd1, 16'h7fff, 16, "R7");
    chk("R7", ovf, 1);
    step(1'b1, 3'd3, 16'h00ff, 0, "R7");
    step(1'b1, 3'd6, 16'h0000, 0, "R10");
    step(1'b1, 3'd1, 16'h0000, 0, "R7");
    chk("R7", ovf, 1);
    step(1'b1, 3'd0, 16'h0001, 0, "R7");
    chk("R7", ovf, 0);
    // subtract overflow at the negative edge, R4
    step(1'b1, 3'd0, 16'h8000, 16, "R2");
    step(1'b1, 3'd2, 16'h0001, 0, "R4");
    chk("R4", ovf, 1);
    // reset mid-run, R1
    @(negedge clk);
    rst_n = 1'b0;
    m_acc = '0; m_ovf = 1'b0;
    #1 check_state("R1");
    @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule